// File: doc/BRIEF.md
# Lane-Split Prefix Adder

This block is the closing carry-propagate adder of a packed-integer datapath. It takes the two vectors left by a carry-save reduction tree, or any two operands, and adds them in one of three lane layouts: a single 32-bit lane, two independent 16-bit lanes, or four independent 8-bit lanes. All layouts share one parallel prefix carry network of minimum depth. It has log2(32) = 5 levels of generate/propagate combining, and its partitioning adds no levels.

Lanes are separated by cutting the carry chain. At every active lane seam, the generate/propagate pair of the bit just below the seam is replaced by the carry-in of the lane above, with propagate forced low. The carry chain therefore restarts at each lane's own carry-in, and nothing leaks upward from the lane beneath. The real carry-out and signed overflow of each lane are still formed from the unmodified bit terms at the lane's top bit. Flags are reported per 8-bit slice, and only the slice that holds a lane's top bit carries them. The block is purely combinational.

Top module: `lane_split_adder`

## Requirements
- R1: With `mode_i` = 0 (one lane), `{cout_o[3], sum_o}` equals `a_i + b_i + cin_i[0]` taken over 32 bits.
- R2: With `mode_i` = 1 (two lanes), the lane over bits 15:0 adds with carry-in `cin_i[0]` and reports its carry-out on `cout_o[1]`. The lane over bits 31:16 adds with carry-in `cin_i[2]` and reports its carry-out on `cout_o[3]`.
- R3: With `mode_i` = 2 (four lanes), slice k over bits 8k+7:8k adds with carry-in `cin_i[k]` and reports its carry-out on `cout_o[k]`.
- R4: `mode_i` = 3 behaves exactly like `mode_i` = 2.
- R5: No carry crosses an active lane seam. A lower lane that overflows, for example 0xFF + 0x01, leaves the result of the lane above it unchanged.
- R6: A `cin_i` bit that does not belong to the lowest slice of an active lane has no effect on any output. The `cout_o` and `ovf_o` bits of a slice that is not the top slice of a lane read 0.
- R7: For each lane, the `ovf_o` bit at its top slice is 1 exactly when the two's-complement sum of the lane operands plus its carry-in lies outside the signed range of the lane width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First addend |
| b_i | input | 32 | Second addend |
| mode_i | input | 2 | Lane layout: 0 one 32-bit, 1 two 16-bit, 2 or 3 four 8-bit |
| cin_i | input | 4 | Per-slice carry-in; only a lane's lowest slice is used |
| sum_o | output | 32 | Lane-wise sum |
| cout_o | output | 4 | Per-slice carry-out, valid at lane top slices, 0 elsewhere |
| ovf_o | output | 4 | Per-slice signed overflow, valid at lane top slices, 0 elsewhere |

## Verification
The checks evaluate the ports combinationally. They assume every input holds a settled 0/1 value whenever the checks run, and that `mode_i` is one of its four codes. The bench drives all inputs from time zero, changes them only on the falling clock edge and compares results well after. Operands come from a table of boundary values per slice (0, 1, the signed limits, all-ones) combined with every carry-in pattern, plus pseudo-random words. Every one of them is applied in each of the four mode codes, so each layout, seam and flag position is exercised in every mode.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_TWO  = 2'd1,
    MODE_FOUR = 2'd2,
    MODE_FOUR_ALT = 2'd3
  } lane_mode_e;

  // slices grouped into one lane for a given mode
  function automatic int unsigned slices_per_lane(input logic [1:0] mode, input int unsigned nslice);
    case (mode)
      MODE_ONE: return nslice;
      MODE_TWO: return nslice / 2;
      default:  return 1;
    endcase
  endfunction

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

endpackage

// File: rtl/lsa_pg_stage.sv
module lsa_pg_stage #(
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned NSLICE  = 4,
  localparam int unsigned W      = SLICE_W * NSLICE
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [NSLICE-1:0] cin_i,
  input  logic [NSLICE-1:0] seam_i,    // seam_i[k]: slice k starts a lane
  output logic [W-1:0]      g_raw_o,
  output logic [W-1:0]      p_raw_o,
  output logic [W-1:0]      g_fwd_o,
  output logic [W-1:0]      p_fwd_o
);

  assign g_raw_o = a_i & b_i;
  assign p_raw_o = a_i ^ b_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int unsigned SL  = i / SLICE_W;
    localparam bit IS_TOP = ((i % SLICE_W) == SLICE_W - 1);
    if (i == 0) begin : g_lsb
      // fold the lowest carry-in into bit 0
      assign g_fwd_o[i] = g_raw_o[i] | (p_raw_o[i] & cin_i[0]);
      assign p_fwd_o[i] = 1'b0;
    end else if (IS_TOP && (SL < NSLICE - 1)) begin : g_seam
      // next lane's carry-in replaces this bit's terms at an active seam
      assign g_fwd_o[i] = seam_i[SL+1] ? cin_i[SL+1] : g_raw_o[i];
      assign p_fwd_o[i] = seam_i[SL+1] ? 1'b0        : p_raw_o[i];
    end else begin : g_plain
      assign g_fwd_o[i] = g_raw_o[i];
      assign p_fwd_o[i] = p_raw_o[i];
    end
  end

endmodule

// File: rtl/lsa_prefix_tree.sv
module lsa_prefix_tree #(
  parameter int unsigned W = 32,
  localparam int unsigned LEVELS = $clog2(W)
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] gg_o     // group generate over bits i..0
);

  logic [W-1:0] g_lv [LEVELS+1];
  logic [W-1:0] p_lv [LEVELS+1];

  assign g_lv[0] = g_i;
  assign p_lv[0] = p_i;

  // minimum-depth Ladner-Fischer: at level l, bit i with bit l set
  // combines with the top bit of the block below it
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_node
      if (((i >> l) & 1) == 1) begin : g_op
        localparam int unsigned J = ((i >> l) << l) - 1;
        assign g_lv[l+1][i] = g_lv[l][i] | (p_lv[l][i] & g_lv[l][J]);
        assign p_lv[l+1][i] = p_lv[l][i] & p_lv[l][J];
      end else begin : g_pass
        assign g_lv[l+1][i] = g_lv[l][i];
        assign p_lv[l+1][i] = p_lv[l][i];
      end
    end
  end

  assign gg_o = g_lv[LEVELS];

endmodule

// File: rtl/lsa_post_stage.sv
module lsa_post_stage #(
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned NSLICE  = 4,
  localparam int unsigned W      = SLICE_W * NSLICE
) (
  input  logic [W-1:0]      g_raw_i,
  input  logic [W-1:0]      p_raw_i,
  input  logic [W-1:0]      gg_i,
  input  logic              cin0_i,
  input  logic [NSLICE-1:0] top_i,     // top_i[k]: slice k ends a lane
  output logic [W-1:0]      sum_o,
  output logic [NSLICE-1:0] cout_o,
  output logic [NSLICE-1:0] ovf_o
);

  logic [W-1:0] c_in;   // carry into each bit

  assign c_in  = {gg_i[W-2:0], cin0_i};
  assign sum_o = p_raw_i ^ c_in;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    localparam int unsigned T = k * SLICE_W + SLICE_W - 1;
    logic co;
    // true carry-out from unforced terms at the lane's top bit
    assign co        = g_raw_i[T] | (p_raw_i[T] & c_in[T]);
    assign cout_o[k] = top_i[k] & co;
    assign ovf_o[k]  = top_i[k] & (co ^ c_in[T]);
  end

endmodule

// File: rtl/lane_split_adder.sv
module lane_split_adder
  import lsa_pkg::*;
#(
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned NSLICE  = 4,
  localparam int unsigned W      = SLICE_W * NSLICE
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [1:0]        mode_i,
  input  logic [NSLICE-1:0] cin_i,
  output logic [W-1:0]      sum_o,
  output logic [NSLICE-1:0] cout_o,
  output logic [NSLICE-1:0] ovf_o
);

  logic [NSLICE-1:0] seam, top, cin_eff;
  logic [W-1:0]      g_raw, p_raw, g_fwd, p_fwd, gg;

  always_comb begin
    int unsigned spl;
    spl = slices_per_lane(mode_i, NSLICE);
    for (int unsigned k = 0; k < NSLICE; k++) begin
      seam[k] = ((k % spl) == 0);
      top[k]  = ((k % spl) == spl - 1);
    end
  end

  assign cin_eff = cin_i & seam;

  lsa_pg_stage #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_pg (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_eff), .seam_i(seam),
    .g_raw_o(g_raw), .p_raw_o(p_raw), .g_fwd_o(g_fwd), .p_fwd_o(p_fwd)
  );

  lsa_prefix_tree #(.W(W)) u_tree (
    .g_i(g_fwd), .p_i(p_fwd), .gg_o(gg)
  );

  lsa_post_stage #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_post (
    .g_raw_i(g_raw), .p_raw_i(p_raw), .gg_i(gg), .cin0_i(cin_eff[0]),
    .top_i(top), .sum_o(sum_o), .cout_o(cout_o), .ovf_o(ovf_o)
  );

endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned NSLICE  = 4,
  localparam int unsigned W      = SLICE_W * NSLICE,
  localparam int unsigned H      = W / 2
) (
  input logic [W-1:0]      a_i,
  input logic [W-1:0]      b_i,
  input logic [1:0]        mode_i,
  input logic [NSLICE-1:0] cin_i,
  input logic [W-1:0]      sum_o,
  input logic [NSLICE-1:0] cout_o,
  input logic [NSLICE-1:0] ovf_o
);

  always_comb begin
    if (mode_i == 2'd0) begin
      assert_sum_one_R1: assert ({cout_o[NSLICE-1], sum_o} == {1'b0, a_i} + {1'b0, b_i} + W'(cin_i[0]))
        else $error("R1 one-lane sum mismatch");
      assert_ovf_one_R7: assert (ovf_o[NSLICE-1] ==
                                 ((a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1])))
        else $error("R7 one-lane overflow mismatch");
      assert_quiet_one_R6: assert (cout_o[NSLICE-2:0] == '0 && ovf_o[NSLICE-2:0] == '0)
        else $error("R6 inner flags not quiet");
    end
    if (mode_i == 2'd1) begin
      assert_sum_lo_R2: assert ({cout_o[NSLICE/2-1], sum_o[H-1:0]} ==
                                {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + H'(cin_i[0]))
        else $error("R2 low lane mismatch");
      assert_sum_hi_R2: assert ({cout_o[NSLICE-1], sum_o[W-1:H]} ==
                                {1'b0, a_i[W-1:H]} + {1'b0, b_i[W-1:H]} + H'(cin_i[NSLICE/2]))
        else $error("R2 high lane mismatch");
    end
    if (mode_i[1]) begin
      for (int k = 0; k < NSLICE; k++) begin
        assert_sum_slice_R3: assert ({cout_o[k], sum_o[k*SLICE_W +: SLICE_W]} ==
                                     {1'b0, a_i[k*SLICE_W +: SLICE_W]} +
                                     {1'b0, b_i[k*SLICE_W +: SLICE_W]} + SLICE_W'(cin_i[k]))
          else $error("R3 slice mismatch");
        assert_ovf_slice_R7: assert (ovf_o[k] ==
            ((a_i[k*SLICE_W+SLICE_W-1] == b_i[k*SLICE_W+SLICE_W-1]) &&
             (sum_o[k*SLICE_W+SLICE_W-1] != a_i[k*SLICE_W+SLICE_W-1])))
          else $error("R7 slice overflow mismatch");
      end
    end
  end

endmodule

bind lane_split_adder lsa_checker #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_lsa_chk (
  .a_i(a_i), .b_i(b_i), .mode_i(mode_i), .cin_i(cin_i),
  .sum_o(sum_o), .cout_o(cout_o), .ovf_o(ovf_o)
);

// File: tb/lane_split_adder_tb_top.sv
module lane_split_adder_tb_top;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] a, b, sum;
  logic [1:0]  mode;
  logic [3:0]  cin, cout, ovf;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  lane_split_adder dut_i (
    .a_i(a), .b_i(b), .mode_i(mode), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  initial begin
    a = '0; b = '0; mode = '0; cin = '0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, cycles=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // expected outputs from lane arithmetic
  task automatic expect_out(output logic [31:0] es, output logic [3:0] ec, output logic [3:0] eo);
    int spl, lw;
    es = '0; ec = '0; eo = '0;
    spl = (mode == 2'd0) ? 4 : (mode == 2'd1) ? 2 : 1;
    lw  = spl * 8;
    for (int l = 0; l < 4 / spl; l++) begin
      longint ua, ub, sa, sb, us, ss, lim;
      int lo;
      lo  = l * lw;
      ua  = longint'((a >> lo) & ((64'd1 << lw) - 1));
      ub  = longint'((b >> lo) & ((64'd1 << lw) - 1));
      us  = ua + ub + longint'(cin[l*spl]);
      lim = longint'(64'd1 << (lw - 1));
      sa  = (ua >= lim) ? ua - 2*lim : ua;
      sb  = (ub >= lim) ? ub - 2*lim : ub;
      ss  = sa + sb + longint'(cin[l*spl]);
      for (int i = 0; i < lw; i++) es[lo+i] = us[i];
      ec[l*spl+spl-1] = us[lw];
      eo[l*spl+spl-1] = (ss >= lim) || (ss < -lim);
    end
  endtask

  task automatic apply(input logic [31:0] av, input logic [31:0] bv,
                       input logic [1:0] mv, input logic [3:0] cv, input string tag);
    logic [31:0] es;
    logic [3:0]  ec, eo;
    @(negedge clk);
    a = av; b = bv; mode = mv; cin = cv;
    @(posedge clk);
    #3;
    expect_out(es, ec, eo);
    n_vec = n_vec + 1;
    if (sum !== es || cout !== ec || ovf !== eo) begin
      n_bad = n_bad + 1;
      $display("FAIL %s mode=%0d a=%h b=%h cin=%b: got sum=%h cout=%b ovf=%b expected sum=%h cout=%b ovf=%b",
               tag, mv, av, bv, cv, sum, cout, ovf, es, ec, eo);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R1/R6/R7";
      2'd1: return "R2/R6/R7";
      2'd2: return "R3/R6/R7";
      default: return "R4/R3/R7";
    endcase
  endfunction

  logic [7:0] edge_v [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h55};
  logic [31:0] lfsr = 32'hACE1_2468;

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: zero inputs give zero outputs
    apply(32'h0, 32'h0, 2'd0, 4'h0, "R1 reset-state");

    // R5: lower lane overflow must not reach the upper lane
    apply(32'h0000_00FF, 32'h0000_0001, 2'd2, 4'h0, "R5 seam8");
    apply(32'h0000_FFFF, 32'h0000_0001, 2'd1, 4'h0, "R5 seam16");
    apply(32'h00FF_FFFF, 32'h0000_0000, 2'd3, 4'b0001, "R5 seam-alt");
    apply(32'h0000_FFFF, 32'h0000_0000, 2'd0, 4'b0001, "R1 full ripple");
    // R6: ignored carry-ins
    apply(32'h1234_5678, 32'h0F0F_0F0F, 2'd0, 4'b1110, "R6 ignored cin one-lane");
    apply(32'h1234_FFFF, 32'h0F0F_0000, 2'd1, 4'b1010, "R6 ignored cin two-lane");

    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          for (int c = 0; c < 16; c++) begin
            apply({edge_v[i], edge_v[j], edge_v[(i+j)%8], edge_v[i]},
                  {edge_v[j], edge_v[(i+3)%8], edge_v[i], edge_v[j]},
                  2'(m), 4'(c), mode_tag(2'(m)));
          end
        end
      end
      for (int r = 0; r < 2000; r++) begin
        logic [31:0] av;
        lfsr = step(lfsr); av = lfsr;
        lfsr = step(lfsr);
        apply(av, lfsr, 2'(m), lfsr[7:4], mode_tag(2'(m)));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule